// File: doc/BRIEF.md
# Shared-Bus Serial Memory Controller

This block sits between a small 8-bit processor and two external serial memories that share one SPI bus: a program ROM and a data RAM. Each device has its own active-low chip select, and both share the clock, the controller-to-device data line and the device-to-controller data line. The core raises a request with one of three operations: instruction fetch, data read or data write. The controller builds the device address, shifts out a command and the address, then moves one data byte. It returns the byte with a one-cycle done strobe.

Fetch addresses come straight from the program counter, starting at ROM offset zero. Data addresses are built from two core registers. The page register gives the upper byte and the offset register gives the lower byte, and both sit inside a fixed RAM region whose upper address byte is 0x01. A pin on the bidirectional bank chooses a two-byte or a three-byte address phase for each transaction. The block has no start or enable input. A request present in the first cycle after reset is served at once.

Top module: `spi_mem_ctrl`

## Requirements
- R1: While reset is held, both chip selects (uio_out bit 0 for ROM, bit 4 for RAM) are high, SCK (uio_out bit 3) is low, busy and done are low, and uio_oe is 8'h1B.
- R2: A request presented in the first cycle after reset is released is accepted, and busy is high in the following cycle, without any start or enable input.
- R3: A fetch (req_op 0) selects the ROM, sends command 0x03, and then sends the program counter as the address, most significant bit first.
- R4: A read or write addresses the RAM with page in address bits 15:8 and offset in bits 7:0. In three-byte mode the top address byte is 0x01. A fetch in three-byte mode sends 0x00 as the top byte.
- R5: A write (req_op 2) selects the RAM, sends command 0x02, and sends wdata most significant bit first after the address.
- R6: A read (req_op 1) selects the RAM, sends command 0x03, and returns on rdata the byte shifted in after the address.
- R7: uio_in bit 7, sampled when a request is accepted, selects a three-byte address phase (1) or a two-byte one (0). The done pulse comes 2x(32 or 40) cycles after the accepting edge.
- R8: Exactly one chip select goes low per transaction, and both are never low together.
- R9: SPI mode 0 is used. SCK idles low and toggles every clock cycle. MOSI (uio_out bit 1) changes only on a falling SCK edge while a select is low. MISO (uio_in bit 2) is sampled as SCK rises.
- R10: Both chip selects are high in the cycle in which done is asserted, so a select is high for at least one clock between transactions.
- R11: done lasts exactly one cycle. rdata changes only together with done and then holds.
- R12: A request raised while busy is ignored. No second transaction starts from it.
- R13: A write leaves rdata unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request; accepted when busy is low |
| req_op | input | 2 | 0 fetch, 1 read, 2 write |
| pc | input | 16 | Program counter used for fetch address |
| page | input | 8 | RAM page register (address bits 15:8) |
| offset | input | 8 | RAM offset register (address bits 7:0) |
| wdata | input | 8 | Byte to write |
| rdata | output | 8 | Byte from the last fetch or read |
| done | output | 1 | One-cycle completion strobe |
| busy | output | 1 | Transaction in progress |
| uio_in | input | 8 | Bidirectional bank inputs: bit 2 MISO, bit 7 wide-address select |
| uio_out | output | 8 | Bit 0 ROM select, bit 1 MOSI, bit 3 SCK, bit 4 RAM select |
| uio_oe | output | 8 | Output enables for the bidirectional bank |

## Verification
The hardest case to reach from the ports is a second request arriving mid-frame. Only a core that ignores busy produces it, so the bench raises a write request in the middle of a running fetch and then counts chip-select falls at a bus-level device model. A read-back after a write in the other address width shows that the data path works independently of the bench's own expectation map. The model decodes every frame bit by bit and serves data on falling SCK edges. This tests the sampling edge, and the width pin is changed between transactions.

// File: rtl/spi_mem_pkg.sv
`timescale 1ns/1ps
package spi_mem_pkg;

    typedef enum logic [1:0] {
        OP_FETCH = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } st_e;

    localparam logic [7:0] CMD_RD = 8'h03;
    localparam logic [7:0] CMD_WR = 8'h02;

    localparam int PIN_CS_ROM = 0;
    localparam int PIN_MOSI   = 1;
    localparam int PIN_MISO   = 2;
    localparam int PIN_SCK    = 3;
    localparam int PIN_CS_RAM = 4;
    localparam int PIN_WIDE   = 7;

endpackage

// File: rtl/spi_mem_frame.sv
`timescale 1ns/1ps
module spi_mem_frame
    import spi_mem_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int HI_W   = 8,
    parameter logic [HI_W-1:0] RAM_REGION = 'h01,
    localparam int ADDR_W  = 2 * DATA_W,
    localparam int FRAME_W = DATA_W + HI_W + ADDR_W + DATA_W,
    localparam int CNT_W   = $clog2(FRAME_W)
) (
    input  op_e                 op,
    input  logic                wide,
    input  logic [ADDR_W-1:0]   pc,
    input  logic [DATA_W-1:0]   page,
    input  logic [DATA_W-1:0]   offset,
    input  logic [DATA_W-1:0]   wdata,
    output logic [FRAME_W-1:0]  frame,
    output logic [CNT_W-1:0]    last,
    output logic                to_ram
);
    logic [DATA_W-1:0] cmd;
    logic [HI_W-1:0]   hi;
    logic [ADDR_W-1:0] lo;

    always_comb begin
        to_ram = (op != OP_FETCH);
        cmd    = (op == OP_WRITE) ? DATA_W'(CMD_WR) : DATA_W'(CMD_RD);
        hi     = to_ram ? RAM_REGION : '0;
        lo     = to_ram ? {page, offset} : pc;
        if (wide) begin
            frame = {cmd, hi, lo, wdata};
            last  = CNT_W'(FRAME_W - 1);
        end else begin
            frame = {cmd, lo, wdata, {HI_W{1'b0}}};
            last  = CNT_W'(FRAME_W - 1 - HI_W);
        end
    end
endmodule

// File: rtl/spi_mem_pins.sv
`timescale 1ns/1ps
module spi_mem_pins
    import spi_mem_pkg::*;
(
    input  logic       sel,
    input  logic       ram,
    input  logic       sck,
    input  logic       mosi,
    output logic [7:0] uio_out,
    output logic [7:0] uio_oe
);
    always_comb begin
        uio_out             = '0;
        uio_out[PIN_CS_ROM] = !(sel && !ram);
        uio_out[PIN_CS_RAM] = !(sel && ram);
        uio_out[PIN_SCK]    = sck;
        uio_out[PIN_MOSI]   = mosi;

        uio_oe              = '0;
        uio_oe[PIN_CS_ROM]  = 1'b1;
        uio_oe[PIN_MOSI]    = 1'b1;
        uio_oe[PIN_SCK]     = 1'b1;
        uio_oe[PIN_CS_RAM]  = 1'b1;
    end
endmodule

// File: rtl/spi_mem_ctrl.sv
`timescale 1ns/1ps
module spi_mem_ctrl
    import spi_mem_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int HI_W   = 8,
    parameter logic [HI_W-1:0] RAM_REGION = 'h01,
    localparam int ADDR_W  = 2 * DATA_W,
    localparam int FRAME_W = DATA_W + HI_W + ADDR_W + DATA_W,
    localparam int CNT_W   = $clog2(FRAME_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] page,
    input  logic [DATA_W-1:0] offset,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic              busy,
    input  logic [7:0]        uio_in,
    output logic [7:0]        uio_out,
    output logic [7:0]        uio_oe
);
    typedef struct packed {
        st_e                st;
        logic [FRAME_W-1:0] tx;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   last;
        logic               sck;
        logic               sel;
        logic               ram;
        logic               wr;
        logic [DATA_W-1:0]  rx;
        logic [DATA_W-1:0]  rdata;
        logic               done;
    } ctl_t;

    ctl_t q, d;

    logic [FRAME_W-1:0] frame_w;
    logic [CNT_W-1:0]   last_w;
    logic               to_ram_w;
    logic               miso;
    op_e                op_w;
    logic               unused_pins;

    assign op_w        = op_e'(req_op);
    assign miso        = uio_in[PIN_MISO];
    assign unused_pins = ^{uio_in[6:3], uio_in[1:0]};

    spi_mem_frame #(
        .DATA_W     (DATA_W),
        .HI_W       (HI_W),
        .RAM_REGION (RAM_REGION)
    ) u_frame (
        .op     (op_w),
        .wide   (uio_in[PIN_WIDE]),
        .pc     (pc),
        .page   (page),
        .offset (offset),
        .wdata  (wdata),
        .frame  (frame_w),
        .last   (last_w),
        .to_ram (to_ram_w)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st   = ST_SHIFT;
                    d.tx   = frame_w;
                    d.cnt  = '0;
                    d.last = last_w;
                    d.sck  = 1'b0;
                    d.sel  = 1'b1;
                    d.ram  = to_ram_w;
                    d.wr   = (op_w == OP_WRITE);
                end
            end
            ST_SHIFT: begin
                if (!q.sck) begin
                    d.sck = 1'b1;
                    d.rx  = {q.rx[DATA_W-2:0], miso};
                end else begin
                    d.sck = 1'b0;
                    if (q.cnt == q.last) begin
                        d.st   = ST_GAP;
                        d.sel  = 1'b0;
                        d.done = 1'b1;
                        if (!q.wr) begin
                            d.rdata = q.rx;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                        d.tx  = {q.tx[FRAME_W-2:0], 1'b0};
                    end
                end
            end
            ST_GAP: begin
                d.st = ST_IDLE;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    spi_mem_pins u_pins (
        .sel     (q.sel),
        .ram     (q.ram),
        .sck     (q.sck),
        .mosi    (q.tx[FRAME_W-1]),
        .uio_out (uio_out),
        .uio_oe  (uio_oe)
    );

    assign rdata = q.rdata;
    assign done  = q.done;
    assign busy  = (q.st != ST_IDLE);
endmodule

// File: rtl/spi_mem_ctrl_chk.sv
`timescale 1ns/1ps
module spi_mem_ctrl_chk
    import spi_mem_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        uio_out,
    input logic              done,
    input logic              busy,
    input logic [DATA_W-1:0] rdata
);
    logic cs_rom, cs_ram, sck, mosi, idle;
    assign cs_rom = uio_out[PIN_CS_ROM];
    assign cs_ram = uio_out[PIN_CS_RAM];
    assign sck    = uio_out[PIN_SCK];
    assign mosi   = uio_out[PIN_MOSI];
    assign idle   = cs_rom && cs_ram;

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !(!cs_rom && !cs_ram));                                          // R8
    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !sck);                                                  // R9
    AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && $past(!idle) && !($past(sck) && !sck)) |-> $stable(mosi)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                 // R11
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> done);                                       // R11
    AST_GAP_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> idle);                                                  // R10
    AST_SELECT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> busy);                                                 // R8
endmodule

bind spi_mem_ctrl spi_mem_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .uio_out (uio_out),
    .done    (done),
    .busy    (busy),
    .rdata   (rdata)
);

// File: tb/spi_mem_ctrl_tb.sv
`timescale 1ns/1ps
module spi_mem_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [15:0] pc = '0;
    logic [7:0]  page = '0, offset = '0, wdata = '0;
    logic [7:0]  rdata;
    logic        done, busy;
    logic [7:0]  uio_in, uio_out, uio_oe;
    logic        mode24 = 1'b0;
    logic        miso_r = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    assign uio_in = {mode24, 4'b0000, miso_r, 2'b00};

    spi_mem_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .pc(pc), .page(page), .offset(offset), .wdata(wdata),
        .rdata(rdata), .done(done), .busy(busy),
        .uio_in(uio_in), .uio_out(uio_out), .uio_oe(uio_oe)
    );

    wire cs_rom_w  = uio_out[0];
    wire mosi_w    = uio_out[1];
    wire sck_w     = uio_out[3];
    wire cs_ram_w  = uio_out[4];
    wire cs_idle_w = cs_rom_w & cs_ram_w;

    function automatic logic [7:0] rom_fn(input logic [15:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] ram_init(input logic [15:0] a);
        return a[15:8] + a[7:0] + 8'h33;
    endfunction

    // ---------------- bus-level memory model ----------------
    int          s_cnt = 0, s_hdr = 24, s_frames = 0;
    logic [7:0]  s_cmd = '0, s_wbyte = '0, s_obyte = '0;
    logic [23:0] s_addr = '0;
    logic        s_rom = 1'b0, s_ram = 1'b0;
    logic [7:0]  sl_ram [logic [15:0]];
    logic [7:0]  exp_ram [logic [15:0]];

    always @(negedge cs_idle_w) begin
        s_cnt = 0; s_addr = '0; s_cmd = '0; s_wbyte = '0;
        s_rom = !cs_rom_w; s_ram = !cs_ram_w;
        s_hdr = mode24 ? 32 : 24;
        s_frames = s_frames + 1;
    end

    always @(posedge sck_w) begin
        if (cs_idle_w === 1'b0) begin
            if (s_cnt < 8)           s_cmd   = {s_cmd[6:0], mosi_w};
            else if (s_cnt < s_hdr)  s_addr  = {s_addr[22:0], mosi_w};
            else                     s_wbyte = {s_wbyte[6:0], mosi_w};
            s_cnt = s_cnt + 1;
            if (s_cnt == s_hdr) begin
                if (s_rom) s_obyte = rom_fn(s_addr[15:0]);
                else if (sl_ram.exists(s_addr[15:0])) s_obyte = sl_ram[s_addr[15:0]];
                else s_obyte = ram_init(s_addr[15:0]);
            end
            if (s_cnt == s_hdr + 8 && s_ram && s_cmd == 8'h02)
                sl_ram[s_addr[15:0]] = s_wbyte;
        end
    end

    always @(negedge sck_w) begin
        if (cs_idle_w === 1'b0 && s_cnt >= s_hdr && s_cnt < s_hdr + 8)
            miso_r = s_obyte[7 - (s_cnt - s_hdr)];
    end

    // ---------------- pin rule monitor ----------------
    int   mosi_bad = 0, both_bad = 0, sck_bad = 0;
    logic p_idle = 1'b1, p_sck = 1'b0, p_mosi = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cs_idle_w && !p_idle && mosi_w != p_mosi && !(p_sck && !sck_w)) mosi_bad++;
            if (!cs_rom_w && !cs_ram_w) both_bad++;
            if (cs_idle_w && sck_w) sck_bad++;
        end
        p_idle = cs_idle_w; p_sck = sck_w; p_mosi = mosi_w;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [1:0] op, input logic m24, input logic [15:0] a,
                        input logic [7:0] wd, input bit rel_rst);
        int n;
        int f0;
        int nb;
        logic [7:0]  prev_rd, exp_rd;
        logic [23:0] exp_a;
        @(negedge clk);
        if (rel_rst) rst_n = 1'b1;
        mode24 = m24; req_op = op; pc = a; page = a[15:8]; offset = a[7:0]; wdata = wd;
        req_valid = 1'b1;
        prev_rd = rdata; f0 = s_frames;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rel_rst ? "R2 busy after first-cycle request" : "R12 busy after accept", busy, 1);
        n = 1;
        while (!done && n < 200) begin @(negedge clk); n++; end
        nb = m24 ? 40 : 32;
        chk("R7 frame length", n, 2 * nb + 1);
        chk("R8 rom select", s_rom, op == 2'd0);
        chk("R8 ram select", s_ram, op != 2'd0);
        chk("R8 one frame", s_frames - f0, 1);
        chk(op == 2'd0 ? "R3 command" : (op == 2'd2 ? "R5 command" : "R6 command"),
            s_cmd, op == 2'd2 ? 8'h02 : 8'h03);
        exp_a = m24 ? {(op == 2'd0) ? 8'h00 : 8'h01, a} : {8'h00, a};
        chk(op == 2'd0 ? "R3 address" : "R4 address", s_addr, exp_a);
        if (op == 2'd2) begin
            chk("R5 write data", s_wbyte, wd);
            exp_ram[a] = wd;
            exp_rd = prev_rd;
        end else if (op == 2'd0) begin
            exp_rd = rom_fn(a);
        end else begin
            exp_rd = exp_ram.exists(a) ? exp_ram[a] : ram_init(a);
        end
        chk(op == 2'd2 ? "R13 rdata kept" : (op == 2'd0 ? "R3 rdata" : "R6 rdata"), rdata, exp_rd);
        chk("R10 selects high at done", {cs_rom_w, cs_ram_w}, 2'b11);
        @(negedge clk);
        chk("R11 done one cycle", done, 0);
        chk("R11 rdata held", rdata, exp_rd);
    endtask

    localparam int NV = 11;
    // {op[1:0], wide, address[15:0], wdata[7:0]}
    localparam logic [26:0] VEC [NV] = '{
        {2'd0, 1'b0, 16'h0001, 8'h00},
        {2'd0, 1'b0, 16'hABCD, 8'h00},
        {2'd2, 1'b1, 16'h1234, 8'h5E},
        {2'd1, 1'b1, 16'h1234, 8'h00},
        {2'd2, 1'b0, 16'h00FF, 8'hA7},
        {2'd1, 1'b0, 16'h00FF, 8'h11},
        {2'd1, 1'b1, 16'h7700, 8'h00},
        {2'd0, 1'b1, 16'hFFFF, 8'h00},
        {2'd2, 1'b1, 16'h8001, 8'h00},
        {2'd1, 1'b0, 16'h8001, 8'hFF},
        {2'd0, 1'b1, 16'h0200, 8'h00}
    };

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int f1;
        repeat (3) @(negedge clk);
        chk("R1 rom select idle", cs_rom_w, 1);
        chk("R1 ram select idle", cs_ram_w, 1);
        chk("R1 sck low", sck_w, 0);
        chk("R1 busy/done low", {busy, done}, 2'b00);
        chk("R1 output enables", uio_oe, 8'h1B);

        xfer(2'd0, 1'b1, 16'h0000, 8'h00, 1'b1);

        for (int i = 0; i < NV; i++)
            xfer(VEC[i][26:25], VEC[i][24], VEC[i][23:8], VEC[i][7:0], 1'b0);

        // R12: request raised in the middle of a fetch is ignored
        @(negedge clk);
        mode24 = 1'b0; req_op = 2'd0; pc = 16'h0102; req_valid = 1'b1;
        f1 = s_frames;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (10) @(negedge clk);
        req_op = 2'd2; page = 8'h44; offset = 8'h55; wdata = 8'h99; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        chk("R12 command of running frame", s_cmd, 8'h03);
        chk("R12 rdata of running frame", rdata, rom_fn(16'h0102));
        repeat (20) @(negedge clk);
        chk("R12 no extra frame", s_frames - f1, 1);
        chk("R12 idle afterwards", busy, 0);

        chk("R9 MOSI moves only on falling SCK", mosi_bad, 0);
        chk("R9 SCK low while idle", sck_bad, 0);
        chk("R8 never both selects low", both_bad, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule